// File: doc/BRIEF.md
# Victim Buffer for a Direct-Mapped First-Level Cache

This block is a small fully associative store placed beside a direct-mapped first-level cache. Conflict misses in such a cache come from several line addresses that share one set. Whatever the first-level cache throws out is written here, so a line that was pushed out recently can be fetched back without a trip to the second level. In effect, the sets that fight over the same location gain a few extra ways.

When the first-level cache misses, it presents the missing line address on the lookup port. In the same cycle it may present the line it is about to displace on the eviction port. All entries are compared against both addresses at once. On a hit, the stored line is returned one cycle later and the displaced line takes the freed slot, so the two lines swap places. On a miss, a forward request carrying the missing address is raised toward the second level one cycle later, and the displaced line is written into the buffer. An empty slot is used first. When no slot is empty, the oldest line in insertion order is overwritten. An eviction may also arrive without a lookup.

Top module: `victim_cache`

## Requirements
- R1: After reset the buffer is empty: `rsp_valid`, `rsp_hit` and `fwd_req` are 0, and the first lookup of any address misses.
- R2: Every cycle with `lk_req` high produces `rsp_valid` high in the next cycle, and only then.
- R3: On a hit, `rsp_hit` is 1 and `rsp_line` carries the line data last stored for that address.
- R4: On a miss, the response has `rsp_hit` 0 and `rsp_line` 0, and in that same cycle `fwd_req` is 1 with `fwd_addr` equal to the looked-up address. A hit never raises `fwd_req`.
- R5: An eviction (`ev_req` high) whose address is not held, and which comes with no lookup or with a missing lookup, is stored. A later lookup of that address hits.
- R6: A hit that comes with an eviction swaps the lines. The hit address leaves the buffer and the evicted line takes its place.
- R7: A hit that comes without an eviction removes the hit line, because the line now lives in the first-level cache.
- R8: An insertion goes into an empty slot when one exists. When the buffer is full, it replaces the line that was inserted longest ago (FIFO order).
- R9: The buffer never holds two copies of one address. An eviction whose address is already held updates that entry's data in place. This includes the case where the eviction has the same address as a same-cycle lookup hit, and then the response returns the old data.
- R10: A line written by a swap counts as the newest line for FIFO replacement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_req | input | 1 | Lookup on a first-level miss |
| lk_addr | input | ADDR_W | Line address being looked up |
| ev_req | input | 1 | A displaced first-level line is offered |
| ev_addr | input | ADDR_W | Line address of the displaced line |
| ev_line | input | LINE_W | Data of the displaced line |
| rsp_valid | output | 1 | Lookup response, one cycle after `lk_req` |
| rsp_hit | output | 1 | Response hit flag |
| rsp_line | output | LINE_W | Line data on a hit, 0 otherwise |
| fwd_req | output | 1 | Miss forwarded to the second level |
| fwd_addr | output | ADDR_W | Line address of the forwarded miss |

## Verification
The directed patterns separate the cases that are easy to confuse:
- an eviction with no lookup, to test plain insertion;
- a hit with no eviction, to test removal;
- a hit paired with an eviction, to test the swap;
- overfilling, to test empty-first placement against FIFO replacement;
- a swap followed by a fresh insert, to show that the swapped line ranks as newest.

Duplicate-address patterns include repeated evictions of one address, an eviction that matches the same-cycle hit, and an eviction that matches a different held entry than the hit. These show whether the buffer keeps exactly one copy and which data the response returns. A long random run over a pool of ten addresses then compares every output, every cycle, against a queue model.

// File: rtl/vc_pkg.sv
// Shared types for the victim buffer.
// Assumes: one replacement-order operation per cycle at most.
package vc_pkg;
    // Operation applied to the insertion-order ranks in a cycle
    typedef enum logic [1:0] {
        AGE_NONE  = 2'd0,   // ranks unchanged
        AGE_TOUCH = 2'd1,   // valid slot becomes newest
        AGE_ALLOC = 2'd2,   // empty slot filled, becomes newest
        AGE_KILL  = 2'd3    // slot leaves, older ranks close the gap
    } age_op_e;
endpackage

// File: rtl/vc_match.sv
// Parallel address comparator over all entries of the buffer.
// Assumes the store keeps addresses unique, so at most one bit of
// hit_vec is set; hit_idx encodes that bit.
module vc_match #(
    parameter int N  = 4,
    parameter int AW = 20,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]         vld,
    input  logic [N-1:0][AW-1:0] tags,
    input  logic [AW-1:0]        addr,
    output logic [N-1:0]         hit_vec,
    output logic                 hit_any,
    output logic [IW-1:0]        hit_idx
);
    // One comparator per entry
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_vec[g] = vld[g] && (tags[g] == addr);
    end

    assign hit_any = |hit_vec;

    // Encode the matching entry number
    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (hit_vec[i]) hit_idx = hit_idx | IW'(i);
        end
    end
endmodule

// File: rtl/vc_age.sv
// Insertion-order tracker. Each valid entry holds a rank equal to the
// number of valid entries inserted after it: 0 is newest and
// count-1 is oldest. It reports the oldest slot as the replacement
// choice. Assumes the caller issues ALLOC only on an empty slot and
// TOUCH/KILL only on a valid one.
module vc_age
    import vc_pkg::*;
#(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  vld,
    input  age_op_e       op,
    input  logic [IW-1:0] slot,
    output logic [IW-1:0] oldest
);
    logic [N-1:0][IW-1:0] rank_q;

    // Update ranks for the cycle's operation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rank_q <= '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                unique case (op)
                    AGE_TOUCH: begin
                        if (IW'(i) == slot)                      rank_q[i] <= '0;
                        else if (vld[i] && rank_q[i] < rank_q[slot]) rank_q[i] <= rank_q[i] + 1'b1;
                    end
                    AGE_ALLOC: begin
                        if (IW'(i) == slot) rank_q[i] <= '0;
                        else if (vld[i])    rank_q[i] <= rank_q[i] + 1'b1;
                    end
                    AGE_KILL: begin
                        if (IW'(i) != slot && vld[i] && rank_q[i] > rank_q[slot])
                            rank_q[i] <= rank_q[i] - 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // Pick the valid entry with the largest rank
    always_comb begin
        logic [IW-1:0] best;
        best   = '0;
        oldest = '0;
        for (int i = 0; i < N; i++) begin
            if (vld[i] && rank_q[i] >= best) begin
                best   = rank_q[i];
                oldest = IW'(i);
            end
        end
    end

    // R8: ranks of valid entries stay below the valid count
    always @(posedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < N; i++) begin
                if (vld[i]) begin
                    rank_range_chk: assert (32'(rank_q[i]) < $countones(vld))
                        else $error("rank out of range");
                end
            end
        end
    end

    // R8
    alloc_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == AGE_ALLOC) |-> !vld[slot]);
endmodule

// File: rtl/vc_store.sv
// Entry storage: valid bit, line address and line data per slot.
// Assumes a write and a clear in one cycle name different slots.
module vc_store #(
    parameter int N  = 4,
    parameter int AW = 20,
    parameter int DW = 32,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [IW-1:0]        wr_slot,
    input  logic [AW-1:0]        wr_addr,
    input  logic [DW-1:0]        wr_data,
    input  logic                 clr_en,
    input  logic [IW-1:0]        clr_slot,
    output logic [N-1:0]         vld,
    output logic [N-1:0][AW-1:0] tags,
    output logic [N-1:0][DW-1:0] lines
);
    // Valid bits: clear on reset, set by writes, dropped by clears
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
        end else begin
            if (clr_en) vld[clr_slot] <= 1'b0;
            if (wr_en)  vld[wr_slot]  <= 1'b1;
        end
    end

    // Address and data payload, written without reset
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tags[wr_slot]  <= wr_addr;
            lines[wr_slot] <= wr_data;
        end
    end

    // R9
    wr_clr_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && clr_en) |-> (wr_slot != clr_slot));

    // R5
    wr_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> vld[$past(wr_slot)]);
endmodule

// File: rtl/victim_cache.sv
// Victim buffer top. Compares a lookup address and an eviction address
// against all entries in one cycle. It answers the lookup one cycle
// later, forwards misses, and swaps, updates, stores or removes lines.
// Assumes the first-level cache sends its displaced line in the same
// cycle as the lookup that caused it, and sends at most one of each
// per cycle.
module victim_cache
    import vc_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int ADDR_W  = 20,
    parameter int LINE_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_req,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic              ev_req,
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic [LINE_W-1:0] ev_line,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [LINE_W-1:0] rsp_line,
    output logic              fwd_req,
    output logic [ADDR_W-1:0] fwd_addr
);
    localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0]             vld;
    logic [ENTRIES-1:0][ADDR_W-1:0] tags;
    logic [ENTRIES-1:0][LINE_W-1:0] lines;
    logic [ENTRIES-1:0]             lk_vec, ev_vec;
    logic                           lk_any, ev_any;
    logic [IW-1:0]                  lk_idx, ev_idx;
    logic [IW-1:0]                  oldest, free_idx;
    logic                           has_free;
    logic                           hit, dup;

    logic                           wr_en, clr_en;
    logic [IW-1:0]                  wr_slot, clr_slot;
    age_op_e                        age_op;
    logic [IW-1:0]                  age_slot;

    vc_match #(.N(ENTRIES), .AW(ADDR_W), .IW(IW)) u_lk_match (
        .vld(vld), .tags(tags), .addr(lk_addr),
        .hit_vec(lk_vec), .hit_any(lk_any), .hit_idx(lk_idx)
    );

    vc_match #(.N(ENTRIES), .AW(ADDR_W), .IW(IW)) u_ev_match (
        .vld(vld), .tags(tags), .addr(ev_addr),
        .hit_vec(ev_vec), .hit_any(ev_any), .hit_idx(ev_idx)
    );

    assign hit = lk_req && lk_any;
    assign dup = ev_req && ev_any;

    // Lowest-numbered empty slot
    always_comb begin
        free_idx = '0;
        has_free = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!vld[i]) begin
                free_idx = IW'(i);
                has_free = 1'b1;
            end
        end
    end

    // Decide writes, clears and the rank operation for this cycle
    always_comb begin
        wr_en    = 1'b0;
        wr_slot  = '0;
        clr_en   = 1'b0;
        clr_slot = '0;
        age_op   = AGE_NONE;
        age_slot = '0;
        if (dup) begin
            wr_en   = 1'b1;
            wr_slot = ev_idx;
            if (hit && lk_idx != ev_idx) begin
                clr_en   = 1'b1;
                clr_slot = lk_idx;
                age_op   = AGE_KILL;
                age_slot = lk_idx;
            end
        end else if (hit) begin
            if (ev_req) begin
                wr_en    = 1'b1;
                wr_slot  = lk_idx;
                age_op   = AGE_TOUCH;
                age_slot = lk_idx;
            end else begin
                clr_en   = 1'b1;
                clr_slot = lk_idx;
                age_op   = AGE_KILL;
                age_slot = lk_idx;
            end
        end else if (ev_req) begin
            wr_en    = 1'b1;
            wr_slot  = has_free ? free_idx : oldest;
            age_op   = has_free ? AGE_ALLOC : AGE_TOUCH;
            age_slot = wr_slot;
        end
    end

    vc_store #(.N(ENTRIES), .AW(ADDR_W), .DW(LINE_W), .IW(IW)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_slot(wr_slot), .wr_addr(ev_addr), .wr_data(ev_line),
        .clr_en(clr_en), .clr_slot(clr_slot),
        .vld(vld), .tags(tags), .lines(lines)
    );

    vc_age #(.N(ENTRIES), .IW(IW)) u_age (
        .clk(clk), .rst_n(rst_n), .vld(vld),
        .op(age_op), .slot(age_slot), .oldest(oldest)
    );

    // Register the lookup response and the miss forward
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_line  <= '0;
            fwd_req   <= 1'b0;
            fwd_addr  <= '0;
        end else begin
            rsp_valid <= lk_req;
            rsp_hit   <= hit;
            rsp_line  <= hit ? lines[lk_idx] : '0;
            fwd_req   <= lk_req && !hit;
            fwd_addr  <= (lk_req && !hit) ? lk_addr : '0;
        end
    end

    // R2
    rsp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> rsp_valid);

    // R4
    fwd_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_req |-> (rsp_valid && fwd_addr == $past(lk_addr)));

    // R4
    hit_no_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> !fwd_req);

    // R9
    single_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_vec) && $onehot0(ev_vec));
endmodule

// File: tb/sim_victim_cache.sv
`timescale 1ns/1ps
module sim_victim_cache;
    localparam int N  = 4;
    localparam int AW = 20;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lk_req = 1'b0;
    logic [AW-1:0] lk_addr = '0;
    logic          ev_req = 1'b0;
    logic [AW-1:0] ev_addr = '0;
    logic [DW-1:0] ev_line = '0;
    logic          rsp_valid, rsp_hit, fwd_req;
    logic [DW-1:0] rsp_line;
    logic [AW-1:0] fwd_addr;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Reference model: oldest line at index 0, newest at the back
    logic [AW-1:0] mq_addr [$];
    logic [DW-1:0] mq_line [$];

    always #2.5 clk = ~clk;

    victim_cache #(.ENTRIES(N), .ADDR_W(AW), .LINE_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .lk_req(lk_req), .lk_addr(lk_addr),
        .ev_req(ev_req), .ev_addr(ev_addr), .ev_line(ev_line),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_line(rsp_line),
        .fwd_req(fwd_req), .fwd_addr(fwd_addr)
    );

    task automatic chk(input string tag, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    // Drive one cycle at a negedge, advance the model, compare at the next negedge
    task automatic step(input bit lk, input logic [AW-1:0] la,
                        input bit ev, input logic [AW-1:0] ea,
                        input logic [DW-1:0] ed, input string tag);
        int h = -1;
        int e = -1;
        bit x_hit;
        logic [DW-1:0] x_line;
        lk_req = lk; lk_addr = la; ev_req = ev; ev_addr = ea; ev_line = ed;
        foreach (mq_addr[i]) begin
            if (lk && mq_addr[i] == la) h = i;
            if (ev && mq_addr[i] == ea) e = i;
        end
        x_hit  = lk && (h >= 0);
        x_line = x_hit ? mq_line[h] : '0;
        if (e >= 0) begin
            mq_line[e] = ed;
            if (x_hit && h != e) begin
                mq_addr.delete(h); mq_line.delete(h);
            end
        end else if (x_hit) begin
            mq_addr.delete(h); mq_line.delete(h);
            if (ev) begin
                mq_addr.push_back(ea); mq_line.push_back(ed);
            end
        end else if (ev) begin
            if (mq_addr.size() == N) begin
                void'(mq_addr.pop_front()); void'(mq_line.pop_front());
            end
            mq_addr.push_back(ea); mq_line.push_back(ed);
        end
        @(negedge clk);
        chk(tag, "rsp_valid", 64'(rsp_valid), 64'(lk));
        chk(tag, "rsp_hit",   64'(rsp_hit),   64'(x_hit));
        chk(tag, "rsp_line",  64'(rsp_line),  64'(x_line));
        chk(tag, "fwd_req",   64'(fwd_req),   64'(lk && !x_hit));
        chk(tag, "fwd_addr",  64'(fwd_addr),  64'((lk && !x_hit) ? la : '0));
    endtask

    task automatic look(input logic [AW-1:0] a, input string tag);
        step(1'b1, a, 1'b0, '0, '0, tag);
    endtask

    task automatic put(input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
        step(1'b0, '0, 1'b1, a, d, tag);
    endtask

    initial begin : watchdog
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: empty after reset
        chk("R1", "rsp_valid", 64'(rsp_valid), 64'd0);
        chk("R1", "fwd_req",   64'(fwd_req),   64'd0);
        look(20'h00100, "R1");
        // R5 / R3 / R7: plain insert, hit, then removal
        put(20'h00010, 32'hAAAA0010, "R5");
        put(20'h00011, 32'hAAAA0011, "R5");
        look(20'h00010, "R3");
        look(20'h00010, "R7");
        look(20'h00123, "R4");
        // R6: swap
        step(1'b1, 20'h00011, 1'b1, 20'h00020, 32'hBBBB0020, "R6");
        look(20'h00011, "R6");
        look(20'h00020, "R6");
        // R8: fill past capacity, then probe all
        for (int i = 0; i < N + 1; i++) put(AW'(20'h30 + i), DW'(32'hC0 + i), "R8");
        for (int i = 0; i < N + 1; i++) look(AW'(20'h30 + i), "R8");
        // R9: same address twice, and same-cycle hit with same-address eviction
        put(20'h00040, 32'hD0D0_0001, "R9");
        put(20'h00040, 32'hD0D0_0002, "R9");
        look(20'h00040, "R9");
        look(20'h00040, "R9");
        put(20'h00050, 32'hE0E0_0001, "R9");
        step(1'b1, 20'h00050, 1'b1, 20'h00050, 32'hE0E0_0002, "R9");
        look(20'h00050, "R9");
        look(20'h00050, "R9");
        put(20'h00060, 32'hF0F0_0060, "R9");
        put(20'h00061, 32'hF0F0_0061, "R9");
        step(1'b1, 20'h00060, 1'b1, 20'h00061, 32'hF1F1_0061, "R9");
        look(20'h00060, "R9");
        look(20'h00061, "R9");
        // R10: a swapped-in line ranks newest
        for (int i = 0; i < N; i++) put(AW'(20'h70 + i), DW'(32'h700 + i), "R10");
        step(1'b1, 20'h00070, 1'b1, 20'h0007E, 32'h0000_07EE, "R10");
        put(20'h0007F, 32'h0000_07FF, "R10");
        look(20'h00071, "R10");
        look(20'h0007E, "R10");
        look(20'h00072, "R10");
        // Random mix over a small address pool
        for (int k = 0; k < 4000; k++) begin
            step(1'($urandom_range(0, 1)), AW'(20'h200 + $urandom_range(0, 9)),
                 1'($urandom_range(0, 1)), AW'(20'h200 + $urandom_range(0, 9)),
                 32'($urandom), "RND");
        end
        step(1'b0, '0, 1'b0, '0, '0, "R2");
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule